// File: doc/BRIEF.md
# AXI Burst Rule Monitor

This block listens passively to one AXI link between a master and a slave. It sees the write address, write data, write response, read address and read data channels, and it never drives any of them. It keeps a small table for each transaction ID so that it can follow outstanding bursts and count their beats. When traffic breaks a bus rule, the block raises a one-cycle pulse and a sticky flag for that rule. Each rule has its own bit.

The block checks the following:
- the shape of each burst: its length against its type, WRAP alignment and length, beat size, and the 4 KB page limit;
- where the last-beat markers fall;
- whether each response ID matches an outstanding request;
- whether a write response arrives before its data;
- whether VALID and its payload stay steady while they wait for READY.

It also keeps one running count per response code for each response channel.

Write data beats are matched to accepted write addresses in the order those addresses were accepted. Each ID may have one write and one read in flight at a time, so up to sixteen of each can be outstanding with the default 4-bit IDs.

Top module: `axiBurstRuleChecker`

## Requirements
- R1: An address handshake with burst code 3, or with a FIXED (code 0) or WRAP (code 2) burst whose length field is above 15, sets rule bit 0. INCR (code 1) bursts of 1 to 256 beats are legal.
- R2: An INCR address handshake sets rule bit 1 when the size-aligned start offset within its 4 KB page plus (length field + 1) << size is greater than 4096. Ending exactly on the page edge is legal.
- R3: An address handshake whose size code exceeds log2 of the data-bus width in bytes sets rule bit 2. With the default 64-bit bus the largest legal size code is 3.
- R4: A WRAP address handshake sets rule bit 3 if its start address is not aligned to the beat size, or if its length field is not 1, 3, 7 or 15.
- R5: Write data beats are counted against the oldest accepted write address that has not finished its data. A beat sets rule bit 4 when the last-beat marker is high before the final beat, or low on the final beat. A beat with the marker high, or the expected final beat, closes that burst.
- R6: Read data beats are counted per ID against that ID's outstanding read. A marker that is early or missing sets rule bit 5. A beat with the marker high, or the expected final beat, closes that read.
- R7: Rule bit 6 is set by any of the following: a write response whose ID has no outstanding write; a read beat whose ID has no outstanding read; a new write or read address on an ID that already has one of that kind in flight. The tracking state is not changed by such an event.
- R8: A write response on an ID whose write is outstanding but whose data is not complete sets rule bit 7. A response after the data is complete retires that write.
- R9: If a channel had VALID high and READY low in one cycle, then in the next cycle VALID must stay high and the payload must not change. Otherwise rule bit 8 is set. The payload is ID, address, length, size and burst on the address channels, the last marker on write data, ID and response on write response, and ID, response and marker on read data.
- R10: A violation shows on `rulePulse` for exactly the cycle after the offending handshake. The same bit is set in `ruleSticky` in that cycle and stays set until `clrFlags` is seen. A violation in the same cycle as `clrFlags` still sets its bit.
- R11: Field k of `bRespTally` (bits k*CNT_W and up) counts accepted write responses with code k, where 0=OKAY, 1=EXOKAY, 2=SLVERR and 3=DECERR. `rRespTally` counts read beats the same way. A field changes one cycle after the handshake.
- R12: The active-low reset clears all tracking tables, tallies and flags. `clrFlags` clears only the sticky flags and leaves the tracking tables untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clrFlags | input | 1 | Clears the sticky rule flags |
| awValid | input | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| awId | input | ID_W | Write address ID |
| awAddr | input | ADDR_W | Write start address |
| awLen | input | 8 | Write burst length minus one |
| awSize | input | 3 | Write beat size code |
| awBurst | input | 2 | Write burst type |
| wValid | input | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| wLast | input | 1 | Write last-beat marker |
| bValid | input | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| bId | input | ID_W | Write response ID |
| bResp | input | 2 | Write response code |
| arValid | input | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| arId | input | ID_W | Read address ID |
| arAddr | input | ADDR_W | Read start address |
| arLen | input | 8 | Read burst length minus one |
| arSize | input | 3 | Read beat size code |
| arBurst | input | 2 | Read burst type |
| rValid | input | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| rId | input | ID_W | Read data ID |
| rResp | input | 2 | Read response code |
| rLast | input | 1 | Read last-beat marker |
| ruleSticky | output | 9 | Sticky violation flag for each rule |
| rulePulse | output | 9 | One-cycle violation pulse for each rule |
| bRespTally | output | 4*CNT_W | Write response count for each code |
| rRespTally | output | 4*CNT_W | Read beat count for each response code |

## Verification
Legal write and read bursts that use several response codes must produce no pulse at all. This separates correct tracking from false alarms.

Each address rule is driven with a just-failing case and, where the rule has a boundary, a just-passing case, for example a burst that ends exactly on the 4 KB page edge. Marker tests use bursts that end early and bursts that never mark their last beat. ID tests use an unknown response ID, a reused request ID, and a read beat arriving after its burst already closed. Together these show whether each burst was retired at the right beat.

Stalled handshakes are tried three ways: held correctly, withdrawn, and held with a changed payload. Clearing the flags is followed by traffic on a still-open read, and a mid-run reset is followed by a beat on a read that was open before the reset. These two cases separate flag clearing from clearing the tracking tables.

// File: rtl/axiChkPkg.sv
package axiChkPkg;

  localparam int NUM_RULES   = 9;
  localparam int RULE_LEN    = 0;
  localparam int RULE_4K     = 1;
  localparam int RULE_SIZE   = 2;
  localparam int RULE_WRAP   = 3;
  localparam int RULE_WLAST  = 4;
  localparam int RULE_RLAST  = 5;
  localparam int RULE_ID     = 6;
  localparam int RULE_EARLYB = 7;
  localparam int RULE_STALL  = 8;

  localparam logic [1:0] BURST_INCR = 2'd1;
  localparam logic [1:0] BURST_WRAP = 2'd2;

  // Strobes passed from the handshake control to the datapath
  typedef struct packed {
    logic awFire;
    logic wFire;
    logic bFire;
    logic arFire;
    logic rFire;
    logic stallErr;
  } chkStrobe_t;

  // Address-phase rule results; bit i corresponds to rule index i (0..3)
  function automatic logic [3:0] addrRules(input logic [11:0] lowAddr,
                                           input logic [7:0]  len,
                                           input logic [2:0]  size,
                                           input logic [1:0]  burst,
                                           input logic [2:0]  maxSize);
    logic [11:0] lowMask;
    logic [16:0] endByte;
    logic [3:0]  bad;
    lowMask = ~(12'hFFF << size);
    endByte = {5'd0, lowAddr & ~lowMask} + ((17'd1 + {9'd0, len}) << size);
    bad = '0;
    bad[RULE_LEN]  = (burst == 2'd3) || ((burst != BURST_INCR) && (len > 8'd15));
    bad[RULE_4K]   = (burst == BURST_INCR) && (endByte > 17'd4096);
    bad[RULE_SIZE] = size > maxSize;
    bad[RULE_WRAP] = (burst == BURST_WRAP) &&
                     (((lowAddr & lowMask) != 12'd0) ||
                      !((len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15)));
    return bad;
  endfunction

endpackage

// File: rtl/axiChkHold.sv
module axiChkHold #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         valid,
  input  logic         ready,
  input  logic [W-1:0] payload,
  output logic         err
);

  logic         pend;
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= 1'b0;
      held <= '0;
    end else begin
      pend <= valid && !ready;
      held <= payload;
    end
  end

  assign err = pend && (!valid || (payload != held));

endmodule

// File: rtl/axiChkCtrl.sv
module axiChkCtrl
  import axiChkPkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      awValid,
  input  logic                      awReady,
  input  logic [ID_W+ADDR_W+12:0]   awPay,
  input  logic                      wValid,
  input  logic                      wReady,
  input  logic                      wLast,
  input  logic                      bValid,
  input  logic                      bReady,
  input  logic [ID_W+1:0]           bPay,
  input  logic                      arValid,
  input  logic                      arReady,
  input  logic [ID_W+ADDR_W+12:0]   arPay,
  input  logic                      rValid,
  input  logic                      rReady,
  input  logic [ID_W+2:0]           rPay,
  output chkStrobe_t                stb
);

  localparam int A_W = ID_W + ADDR_W + 13;

  logic [4:0] chanErr;

  axiChkHold #(.W(A_W)) u_awHold (.clk(clk), .rstN(rstN), .valid(awValid), .ready(awReady),
                                  .payload(awPay), .err(chanErr[0]));
  axiChkHold #(.W(1))   u_wHold  (.clk(clk), .rstN(rstN), .valid(wValid), .ready(wReady),
                                  .payload(wLast), .err(chanErr[1]));
  axiChkHold #(.W(ID_W+2)) u_bHold (.clk(clk), .rstN(rstN), .valid(bValid), .ready(bReady),
                                  .payload(bPay), .err(chanErr[2]));
  axiChkHold #(.W(A_W)) u_arHold (.clk(clk), .rstN(rstN), .valid(arValid), .ready(arReady),
                                  .payload(arPay), .err(chanErr[3]));
  axiChkHold #(.W(ID_W+3)) u_rHold (.clk(clk), .rstN(rstN), .valid(rValid), .ready(rReady),
                                  .payload(rPay), .err(chanErr[4]));

  always_comb begin
    stb.awFire   = awValid && awReady;
    stb.wFire    = wValid && wReady;
    stb.bFire    = bValid && bReady;
    stb.arFire   = arValid && arReady;
    stb.rFire    = rValid && rReady;
    stb.stallErr = |chanErr;
  end

endmodule

// File: rtl/axiChkData.sv
module axiChkData
  import axiChkPkg::*;
#(
  parameter int ID_W     = 4,
  parameter int MAX_SIZE = 3,
  parameter int CNT_W    = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clrFlags,
  input  chkStrobe_t            stb,
  input  logic [ID_W-1:0]       awId,
  input  logic [11:0]           awAddrLow,
  input  logic [7:0]            awLen,
  input  logic [2:0]            awSize,
  input  logic [1:0]            awBurst,
  input  logic                  wLast,
  input  logic [ID_W-1:0]       bId,
  input  logic [1:0]            bResp,
  input  logic [ID_W-1:0]       arId,
  input  logic [11:0]           arAddrLow,
  input  logic [7:0]            arLen,
  input  logic [2:0]            arSize,
  input  logic [1:0]            arBurst,
  input  logic [ID_W-1:0]       rId,
  input  logic [1:0]            rResp,
  input  logic                  rLast,
  output logic [NUM_RULES-1:0]  ruleSticky,
  output logic [NUM_RULES-1:0]  rulePulse,
  output logic [4*CNT_W-1:0]    bRespTally,
  output logic [4*CNT_W-1:0]    rRespTally
);

  localparam int         NID    = 1 << ID_W;
  localparam logic [2:0] SIZE_LIM = 3'(MAX_SIZE);

  logic [NID-1:0]   awBusy, wDone, arBusy;
  logic [7:0]       arLenTab [NID];
  logic [7:0]       rBeat    [NID];
  logic [7:0]       qLen     [NID];
  logic [ID_W-1:0]  qId      [NID];
  logic [ID_W-1:0]  qHead, qTail;
  logic [ID_W:0]    qCnt;
  logic [7:0]       wBeat;
  logic [CNT_W-1:0] bTally [4];
  logic [CNT_W-1:0] rTally [4];

  logic [NUM_RULES-1:0] viol;
  logic [3:0] awBad, arBad;
  logic qHas, wExpLast, wEnd, awTake, arTake, bOk, rHit, rExpLast;

  always_comb begin
    awBad    = addrRules(awAddrLow, awLen, awSize, awBurst, SIZE_LIM);
    arBad    = addrRules(arAddrLow, arLen, arSize, arBurst, SIZE_LIM);
    qHas     = qCnt != '0;
    wExpLast = wBeat == qLen[qHead];
    wEnd     = stb.wFire && qHas && (wLast || wExpLast);
    awTake   = stb.awFire && !awBusy[awId];
    arTake   = stb.arFire && !arBusy[arId];
    bOk      = stb.bFire && awBusy[bId] && wDone[bId];
    rHit     = stb.rFire && arBusy[rId];
    rExpLast = rBeat[rId] == arLenTab[rId];

    viol = '0;
    if (stb.awFire) viol[3:0] = viol[3:0] | awBad;
    if (stb.arFire) viol[3:0] = viol[3:0] | arBad;
    viol[RULE_WLAST]  = stb.wFire && qHas && (wLast != wExpLast);
    viol[RULE_RLAST]  = rHit && (rLast != rExpLast);
    viol[RULE_ID]     = (stb.awFire && awBusy[awId]) || (stb.arFire && arBusy[arId]) ||
                        (stb.bFire && !awBusy[bId]) || (stb.rFire && !arBusy[rId]);
    viol[RULE_EARLYB] = stb.bFire && awBusy[bId] && !wDone[bId];
    viol[RULE_STALL]  = stb.stallErr;
  end

  // Write tracking: in-order address queue plus per-ID state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      awBusy <= '0;
      wDone  <= '0;
      qHead  <= '0;
      qTail  <= '0;
      qCnt   <= '0;
      wBeat  <= '0;
      for (int i = 0; i < NID; i++) begin
        qLen[i] <= '0;
        qId[i]  <= '0;
      end
    end else begin
      if (awTake) begin
        awBusy[awId] <= 1'b1;
        qLen[qTail]  <= awLen;
        qId[qTail]   <= awId;
        qTail        <= qTail + 1'b1;
      end
      if (bOk) begin
        awBusy[bId] <= 1'b0;
        wDone[bId]  <= 1'b0;
      end
      if (stb.wFire && qHas) begin
        if (wEnd) begin
          wBeat              <= '0;
          qHead              <= qHead + 1'b1;
          wDone[qId[qHead]]  <= 1'b1;
        end else begin
          wBeat <= wBeat + 8'd1;
        end
      end
      qCnt <= qCnt + {{ID_W{1'b0}}, awTake} - {{ID_W{1'b0}}, wEnd};
    end
  end

  // Read tracking: one outstanding burst per ID
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arBusy <= '0;
      for (int i = 0; i < NID; i++) begin
        arLenTab[i] <= '0;
        rBeat[i]    <= '0;
      end
    end else begin
      if (arTake) begin
        arBusy[arId]   <= 1'b1;
        arLenTab[arId] <= arLen;
        rBeat[arId]    <= '0;
      end
      if (rHit) begin
        if (rLast || rExpLast) begin
          arBusy[rId] <= 1'b0;
          rBeat[rId]  <= '0;
        end else begin
          rBeat[rId] <= rBeat[rId] + 8'd1;
        end
      end
    end
  end

  // Flags and response tallies
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rulePulse  <= '0;
      ruleSticky <= '0;
      for (int k = 0; k < 4; k++) begin
        bTally[k] <= '0;
        rTally[k] <= '0;
      end
    end else begin
      rulePulse  <= viol;
      ruleSticky <= (clrFlags ? '0 : ruleSticky) | viol;
      if (stb.bFire) bTally[bResp] <= bTally[bResp] + 1'b1;
      if (stb.rFire) rTally[rResp] <= rTally[rResp] + 1'b1;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_tally
    assign bRespTally[k*CNT_W +: CNT_W] = bTally[k];
    assign rRespTally[k*CNT_W +: CNT_W] = rTally[k];
  end

endmodule

// File: rtl/axiBurstRuleChecker.sv
module axiBurstRuleChecker
  import axiChkPkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clrFlags,
  input  logic                 awValid,
  input  logic                 awReady,
  input  logic [ID_W-1:0]      awId,
  input  logic [ADDR_W-1:0]    awAddr,
  input  logic [7:0]           awLen,
  input  logic [2:0]           awSize,
  input  logic [1:0]           awBurst,
  input  logic                 wValid,
  input  logic                 wReady,
  input  logic                 wLast,
  input  logic                 bValid,
  input  logic                 bReady,
  input  logic [ID_W-1:0]      bId,
  input  logic [1:0]           bResp,
  input  logic                 arValid,
  input  logic                 arReady,
  input  logic [ID_W-1:0]      arId,
  input  logic [ADDR_W-1:0]    arAddr,
  input  logic [7:0]           arLen,
  input  logic [2:0]           arSize,
  input  logic [1:0]           arBurst,
  input  logic                 rValid,
  input  logic                 rReady,
  input  logic [ID_W-1:0]      rId,
  input  logic [1:0]           rResp,
  input  logic                 rLast,
  output logic [8:0]           ruleSticky,
  output logic [8:0]           rulePulse,
  output logic [4*CNT_W-1:0]   bRespTally,
  output logic [4*CNT_W-1:0]   rRespTally
);

  localparam int MAX_SIZE = $clog2(DATA_W / 8);

  chkStrobe_t stb;

  axiChkCtrl #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awPay({awId, awAddr, awLen, awSize, awBurst}),
    .wValid(wValid), .wReady(wReady), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bPay({bId, bResp}),
    .arValid(arValid), .arReady(arReady), .arPay({arId, arAddr, arLen, arSize, arBurst}),
    .rValid(rValid), .rReady(rReady), .rPay({rId, rResp, rLast}),
    .stb(stb)
  );

  axiChkData #(.ID_W(ID_W), .MAX_SIZE(MAX_SIZE), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .clrFlags(clrFlags), .stb(stb),
    .awId(awId), .awAddrLow(awAddr[11:0]), .awLen(awLen), .awSize(awSize), .awBurst(awBurst),
    .wLast(wLast), .bId(bId), .bResp(bResp),
    .arId(arId), .arAddrLow(arAddr[11:0]), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
    .rId(rId), .rResp(rResp), .rLast(rLast),
    .ruleSticky(ruleSticky), .rulePulse(rulePulse),
    .bRespTally(bRespTally), .rRespTally(rRespTally)
  );

endmodule

// File: rtl/axiChkAsserts.sv
module axiChkAsserts #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               clrFlags,
  input logic               awValid,
  input logic               awReady,
  input logic               wValid,
  input logic               wReady,
  input logic               bValid,
  input logic               bReady,
  input logic               arValid,
  input logic               arReady,
  input logic               rValid,
  input logic               rReady,
  input logic [8:0]         ruleSticky,
  input logic [8:0]         rulePulse,
  input logic [4*CNT_W-1:0] bRespTally,
  input logic [4*CNT_W-1:0] rRespTally
);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrFlags |=> ((ruleSticky & $past(ruleSticky)) == $past(ruleSticky)));

  // R10
  pulse_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ruleSticky & rulePulse) == rulePulse);

  // R11
  b_tally_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bValid && bReady) |=> $stable(bRespTally));

  // R11
  r_tally_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rValid && rReady) |=> $stable(rRespTally));

  // R1 R2 R3 R4
  addr_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rulePulse[3:0]) |-> $past((awValid && awReady) || (arValid && arReady)));

  // R5
  wlast_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rulePulse[4] |-> $past(wValid && wReady));

  // R6
  rlast_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rulePulse[5] |-> $past(rValid && rReady));

  // R8
  early_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    rulePulse[7] |-> $past(bValid && bReady));

  // R9
  stall_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rulePulse[8] |-> $past((awValid && !awReady) || (wValid && !wReady) || (bValid && !bReady) ||
                           (arValid && !arReady) || (rValid && !rReady), 2));

endmodule

bind axiBurstRuleChecker axiChkAsserts #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .clrFlags(clrFlags),
  .awValid(awValid), .awReady(awReady), .wValid(wValid), .wReady(wReady),
  .bValid(bValid), .bReady(bReady), .arValid(arValid), .arReady(arReady),
  .rValid(rValid), .rReady(rReady),
  .ruleSticky(ruleSticky), .rulePulse(rulePulse),
  .bRespTally(bRespTally), .rRespTally(rRespTally)
);

// File: tb/axiBurstRuleChecker_tb.sv
module axiBurstRuleChecker_tb;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN, clrFlags;
  logic awValid, awReady, wValid, wReady, wLast, bValid, bReady;
  logic arValid, arReady, rValid, rReady, rLast;
  logic [3:0]  awId, bId, arId, rId;
  logic [31:0] awAddr, arAddr;
  logic [7:0]  awLen, arLen;
  logic [2:0]  awSize, arSize;
  logic [1:0]  awBurst, arBurst, bResp, rResp;
  logic [8:0]  ruleSticky, rulePulse;
  logic [4*CNT_W-1:0] bRespTally, rRespTally;

  int nVec = 0;
  int nBad = 0;
  int expB [4];
  int expR [4];
  logic [8:0] expQ [$];
  string      tagQ [$];

  always #10 clk = ~clk;

  axiBurstRuleChecker #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .clrFlags(clrFlags),
    .awValid(awValid), .awReady(awReady), .awId(awId), .awAddr(awAddr), .awLen(awLen),
    .awSize(awSize), .awBurst(awBurst),
    .wValid(wValid), .wReady(wReady), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bId(bId), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arId(arId), .arAddr(arAddr), .arLen(arLen),
    .arSize(arSize), .arBurst(arBurst),
    .rValid(rValid), .rReady(rReady), .rId(rId), .rResp(rResp), .rLast(rLast),
    .ruleSticky(ruleSticky), .rulePulse(rulePulse),
    .bRespTally(bRespTally), .rRespTally(rRespTally)
  );

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Monitor: pulse for the cycle driven at the previous falling edge
  initial forever begin
    @(posedge clk);
    #5;
    if (expQ.size() > 0) begin
      logic [8:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check({55'd0, rulePulse}, {55'd0, e}, t);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  task automatic idle();
    awValid = 0; awReady = 0; awId = 0; awAddr = 0; awLen = 0; awSize = 0; awBurst = 0;
    wValid = 0; wReady = 0; wLast = 0;
    bValid = 0; bReady = 0; bId = 0; bResp = 0;
    arValid = 0; arReady = 0; arId = 0; arAddr = 0; arLen = 0; arSize = 0; arBurst = 0;
    rValid = 0; rReady = 0; rId = 0; rResp = 0; rLast = 0;
  endtask

  task automatic tick(input logic [8:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic sendAw(input logic [3:0] id, input logic [31:0] a, input logic [7:0] len,
                        input logic [2:0] sz, input logic [1:0] bt, input logic [8:0] exp, input string tag);
    awValid = 1; awReady = 1; awId = id; awAddr = a; awLen = len; awSize = sz; awBurst = bt;
    tick(exp, tag);
    awValid = 0; awReady = 0;
  endtask

  task automatic sendAr(input logic [3:0] id, input logic [31:0] a, input logic [7:0] len,
                        input logic [2:0] sz, input logic [1:0] bt, input logic [8:0] exp, input string tag);
    arValid = 1; arReady = 1; arId = id; arAddr = a; arLen = len; arSize = sz; arBurst = bt;
    tick(exp, tag);
    arValid = 0; arReady = 0;
  endtask

  task automatic sendW(input logic last, input logic [8:0] exp, input string tag);
    wValid = 1; wReady = 1; wLast = last;
    tick(exp, tag);
    wValid = 0; wReady = 0; wLast = 0;
  endtask

  task automatic sendB(input logic [3:0] id, input logic [1:0] resp, input logic [8:0] exp, input string tag);
    bValid = 1; bReady = 1; bId = id; bResp = resp;
    expB[resp]++;
    tick(exp, tag);
    bValid = 0; bReady = 0;
  endtask

  task automatic sendR(input logic [3:0] id, input logic [1:0] resp, input logic last,
                       input logic [8:0] exp, input string tag);
    rValid = 1; rReady = 1; rId = id; rResp = resp; rLast = last;
    expR[resp]++;
    tick(exp, tag);
    rValid = 0; rReady = 0; rLast = 0;
  endtask

  task automatic checkTallies(input string tag);
    for (int k = 0; k < 4; k++) begin
      check({48'd0, bRespTally[k*CNT_W +: CNT_W]}, 64'(expB[k]), {tag, " write code"});
      check({48'd0, rRespTally[k*CNT_W +: CNT_W]}, 64'(expR[k]), {tag, " read code"});
    end
  endtask

  initial begin
    idle();
    clrFlags = 0;
    rstN = 0;
    for (int k = 0; k < 4; k++) begin expB[k] = 0; expR[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check({55'd0, ruleSticky}, 64'd0, "R12 sticky after reset");
    check({55'd0, rulePulse}, 64'd0, "R12 pulse after reset");
    checkTallies("R12 tally after reset");

    // Legal traffic: no pulses (R5, R6, R11)
    sendAw(4'd3, 32'h100, 8'd3, 3'd3, 2'd1, 9'h000, "R5 legal write addr");
    sendW(0, 9'h000, "R5 legal beat 0");
    sendW(0, 9'h000, "R5 legal beat 1");
    sendW(0, 9'h000, "R5 legal beat 2");
    sendW(1, 9'h000, "R5 legal last beat");
    sendB(4'd3, 2'd0, 9'h000, "R8 legal response");
    sendAr(4'd5, 32'h200, 8'd1, 3'd2, 2'd1, 9'h000, "R6 legal read addr");
    sendR(4'd5, 2'd1, 0, 9'h000, "R6 legal read beat 0");
    sendR(4'd5, 2'd0, 1, 9'h000, "R6 legal read last");

    // Address-phase rules
    sendAr(4'd6, 32'h0, 8'd16, 3'd2, 2'd0, 9'h001, "R1 FIXED too long");
    sendAr(4'd7, 32'h0, 8'd0, 3'd2, 2'd3, 9'h001, "R1 reserved burst");
    sendAr(4'd8, 32'hFF8, 8'd1, 3'd3, 2'd1, 9'h002, "R2 page crossing");
    sendAr(4'd9, 32'h1FF0, 8'd1, 3'd3, 2'd1, 9'h000, "R2 ends on page edge");
    sendAr(4'd10, 32'h0, 8'd0, 3'd4, 2'd1, 9'h004, "R3 size above bus");
    sendAr(4'd11, 32'h4, 8'd3, 3'd3, 2'd2, 9'h008, "R4 wrap misaligned");
    sendAr(4'd12, 32'h0, 8'd2, 3'd2, 2'd2, 9'h008, "R4 wrap length 3");
    sendAr(4'd13, 32'h20, 8'd7, 3'd2, 2'd2, 9'h000, "R4 legal wrap");
    sendAr(4'd5, 32'h0, 8'd16, 3'd2, 2'd2, 9'h009, "R1 R4 wrap length 17");

    // Write last marker
    sendAw(4'd1, 32'h300, 8'd2, 3'd2, 2'd1, 9'h000, "R5 addr len 3");
    sendW(1, 9'h010, "R5 early marker");
    sendB(4'd1, 2'd2, 9'h000, "R8 response after closed burst");
    sendAw(4'd2, 32'h400, 8'd0, 3'd2, 2'd1, 9'h000, "R5 addr len 1");
    sendW(0, 9'h010, "R5 missing marker");
    sendB(4'd2, 2'd3, 9'h000, "R8 response after missing-marker burst");

    // Read last marker and ID matching
    sendAr(4'd4, 32'h500, 8'd1, 3'd2, 2'd1, 9'h000, "R6 addr len 2");
    sendR(4'd4, 2'd0, 1, 9'h020, "R6 early marker");
    sendR(4'd4, 2'd0, 1, 9'h040, "R7 beat after closed read");
    sendAr(4'd14, 32'h600, 8'd0, 3'd2, 2'd1, 9'h000, "R6 addr len 1");
    sendR(4'd14, 2'd2, 0, 9'h020, "R6 missing marker");
    sendB(4'd9, 2'd1, 9'h040, "R7 unknown write ID");
    sendAr(4'd13, 32'h40, 8'd0, 3'd2, 2'd1, 9'h040, "R7 read ID reuse");

    // Early write response
    sendAw(4'd0, 32'h700, 8'd1, 3'd2, 2'd1, 9'h000, "R8 addr len 2");
    sendB(4'd0, 2'd0, 9'h080, "R8 response before data");
    sendW(0, 9'h000, "R8 beat 0");
    sendW(1, 9'h000, "R8 beat 1");
    sendB(4'd0, 2'd0, 9'h000, "R8 response after data");

    // Handshake stability
    awValid = 1; awReady = 0; awId = 4'd5; awAddr = 32'h800; awLen = 0; awSize = 2; awBurst = 1;
    tick(9'h000, "R9 write addr stalled");
    awValid = 0;
    tick(9'h100, "R9 valid withdrawn");
    arValid = 1; arReady = 0; arId = 4'd15; arAddr = 32'h40; arLen = 0; arSize = 2; arBurst = 1;
    tick(9'h000, "R9 read addr stalled");
    arReady = 1; arAddr = 32'h44;
    tick(9'h100, "R9 payload changed");
    arValid = 1; arReady = 0; arId = 4'd3; arAddr = 32'h80;
    tick(9'h000, "R9 held stall cycle");
    arReady = 1;
    tick(9'h000, "R9 held then accepted");
    arValid = 0; arReady = 0;
    sendR(4'd3, 2'd0, 1, 9'h000, "R6 read after held stall");

    check({55'd0, ruleSticky}, 64'h1FF, "R10 sticky union");
    checkTallies("R11");

    // Flag clearing keeps tracking state
    clrFlags = 1;
    tick(9'h000, "R10 clear cycle");
    clrFlags = 0;
    check({55'd0, ruleSticky}, 64'd0, "R10 sticky cleared");
    sendR(4'd15, 2'd3, 1, 9'h000, "R12 open read survives clear");
    check({55'd0, ruleSticky}, 64'd0, "R12 no flag after clear");
    clrFlags = 1;
    sendB(4'd9, 2'd0, 9'h040, "R10 violation with clear");
    clrFlags = 0;
    check({55'd0, ruleSticky}, 64'h040, "R10 set wins over clear");
    checkTallies("R11 after clear");

    // Mid-run reset clears the tables
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
    for (int k = 0; k < 4; k++) begin expB[k] = 0; expR[k] = 0; end
    @(negedge clk);
    check({55'd0, ruleSticky}, 64'd0, "R12 sticky after second reset");
    checkTallies("R12 tally after second reset");
    sendR(4'd13, 2'd0, 1, 9'h040, "R12 table cleared by reset");
    checkTallies("R11 after reset beat");
    @(negedge clk);
    finishRun();
  end

endmodule